// File: doc/BRIEF.md
# Configuration Device-Select Decoder

This block sits behind the configuration-address register of a host bridge. It turns each type-0 configuration access into a decoded target. The upper part of the address, bits 31 to 11, is a field of device-select lines. A legal access raises exactly one of them. The block checks that field for a single set bit. On a legal pattern it reports:

- the device number,
- a one-hot device select,
- the function number,
- the dword-aligned register offset,
- the access size.

Any other pattern is rejected with an error pulse, and no device is selected.

The host drives the latched address, the access size and a one-cycle strobe. All results are registered. They appear on the clock edge that samples the strobe, so they are visible one cycle later. The valid, type-0 and error flags are single-cycle pulses. The bus number is always zero, because a type-0 cycle only reaches devices on the host's own bus.

Top module: `cfg_devsel_decoder`

## Requirements
- R1: While reset is high, and on the first cycle after it, every output is zero.
- R2: A strobe whose address has exactly one bit set in bits 31..11 gives `dec_valid_o`=1 and `dec_err_o`=0 in the next cycle, for exactly one cycle.
- R3: On a legal decode, `dev_num_o` equals the absolute bit position of the set select line, a value from 11 to 31.
- R4: `devsel_o` has 21 bits. Bit (position − 11) is the only bit set during a valid decode, and `devsel_o` is all-zero in every other cycle.
- R5: A strobe with no bit set in bits 31..11 gives a one-cycle `dec_err_o` pulse in the next cycle. In that cycle `dec_valid_o`=0, `devsel_o`=0 and `dev_num_o`=0.
- R6: A strobe with two or more bits set in bits 31..11 is rejected exactly as in R5.
- R7: On every strobe, `func_num_o` takes address bits 10..8 and `reg_off_o` takes {bits 7..2, 2'b00}. Address bits 1..0 have no effect.
- R8: `type0_o` pulses together with `dec_valid_o` and never on an error. `bus_num_o` is zero at all times.
- R9: `size_o` takes `acc_size_i` on each strobe. The size codes are 1 = byte, 2 = halfword and 4 = word.
- R10: Without a strobe, no valid or error pulse is produced, and changes to the address or size leave the decoded fields unchanged.
- R11: Strobes on consecutive cycles are each decoded, one result per cycle, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_stb_i | input | 1 | One-cycle configuration access strobe |
| cfg_addr_i | input | 32 | Latched configuration address |
| acc_size_i | input | 3 | Access size in bytes (1, 2, 4) |
| dec_valid_o | output | 1 | Legal decode pulse |
| dec_err_o | output | 1 | Illegal select pattern pulse |
| type0_o | output | 1 | Type-0 cycle flag, pulses with valid |
| bus_num_o | output | 8 | Bus number, always zero |
| dev_num_o | output | 5 | Bit position of the select line |
| func_num_o | output | 3 | Function number |
| reg_off_o | output | 8 | Dword-aligned register offset |
| size_o | output | 3 | Forwarded access size |
| devsel_o | output | 21 | One-hot device select |

## Verification
The decode is tried with a single select line at each end of the field (bit 11 and bit 31). This separates an off-by-one in the position base from a truncated index. A single line in the middle is combined with non-zero function, offset and low address bits, which shows that the field split and the forced-zero low bits are independent of the select check. Three illegal patterns are used: an empty field, two adjacent lines, and a fully set field. They tell a "zero bits" test apart from a "more than one bit" test, so a detector that checks only one of the two is caught. Directed cases then cover address changes without a strobe and back-to-back strobes, which expose outputs that are not pulses or that hold stale fields.

// File: rtl/cfg_dec_pkg.sv
package cfg_dec_pkg;
  localparam int CFG_ADDR_W   = 32;
  localparam int CFG_IDSEL_LO = 11;
  localparam int CFG_FN_LO    = 8;
  localparam int CFG_FN_W     = 3;
  localparam int CFG_BUS_W    = 8;
  localparam int CFG_SIZE_W   = 3;

  typedef enum logic [CFG_SIZE_W-1:0] {
    SZ_BYTE = 3'd1,
    SZ_HALF = 3'd2,
    SZ_WORD = 3'd4
  } acc_size_e;
endpackage

// File: rtl/idsel_onehot_check.sv
module idsel_onehot_check #(
  parameter int W     = 21,
  parameter int BASE  = 11,
  parameter int POS_W = 5
) (
  input  logic [W-1:0]     sel_field,
  output logic             legal,
  output logic [POS_W-1:0] pos,
  output logic [W-1:0]     sel_onehot
);
  logic any_set;
  logic many_set;

  assign any_set  = |sel_field;
  assign many_set = |(sel_field & (sel_field - W'(1)));
  assign legal    = any_set && !many_set;

  always_comb begin
    pos = '0;
    for (int i = 0; i < W; i++) begin
      if (sel_field[i]) pos = pos | POS_W'(i + BASE);
    end
    if (!legal) pos = '0;
  end

  assign sel_onehot = legal ? sel_field : '0;
endmodule

// File: rtl/cfg_field_split.sv
module cfg_field_split #(
  parameter int FN_LO = 8,
  parameter int FN_W  = 3
) (
  input  logic [FN_LO+FN_W-1:2] addr_mid,
  output logic [FN_W-1:0]       func,
  output logic [FN_LO-1:0]      reg_off
);
  assign func    = addr_mid[FN_LO+FN_W-1:FN_LO];
  assign reg_off = {addr_mid[FN_LO-1:2], 2'b00};
endmodule

// File: rtl/cfg_devsel_decoder.sv
module cfg_devsel_decoder
  import cfg_dec_pkg::*;
#(
  parameter int ADDR_W   = CFG_ADDR_W,
  parameter int IDSEL_LO = CFG_IDSEL_LO,
  parameter int FN_LO    = CFG_FN_LO,
  parameter int FN_W     = CFG_FN_W,
  parameter int BUS_W    = CFG_BUS_W,
  parameter int SIZE_W   = CFG_SIZE_W,
  parameter int NSEL     = ADDR_W - IDSEL_LO,
  parameter int DEV_W    = $clog2(ADDR_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_stb_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [SIZE_W-1:0] acc_size_i,
  output logic              dec_valid_o,
  output logic              dec_err_o,
  output logic              type0_o,
  output logic [BUS_W-1:0]  bus_num_o,
  output logic [DEV_W-1:0]  dev_num_o,
  output logic [FN_W-1:0]   func_num_o,
  output logic [FN_LO-1:0]  reg_off_o,
  output logic [SIZE_W-1:0] size_o,
  output logic [NSEL-1:0]   devsel_o
);
  logic             legal;
  logic [DEV_W-1:0] pos;
  logic [NSEL-1:0]  sel_onehot;
  logic [FN_W-1:0]  func_c;
  logic [FN_LO-1:0] reg_c;
  logic             unused_addr_lo;

  assign unused_addr_lo = ^cfg_addr_i[1:0];

  idsel_onehot_check #(
    .W(NSEL), .BASE(IDSEL_LO), .POS_W(DEV_W)
  ) u_check (
    .sel_field (cfg_addr_i[ADDR_W-1:IDSEL_LO]),
    .legal     (legal),
    .pos       (pos),
    .sel_onehot(sel_onehot)
  );

  cfg_field_split #(
    .FN_LO(FN_LO), .FN_W(FN_W)
  ) u_split (
    .addr_mid(cfg_addr_i[FN_LO+FN_W-1:2]),
    .func    (func_c),
    .reg_off (reg_c)
  );

  assign bus_num_o = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid_o <= 1'b0;
      dec_err_o   <= 1'b0;
      type0_o     <= 1'b0;
      dev_num_o   <= '0;
      func_num_o  <= '0;
      reg_off_o   <= '0;
      size_o      <= '0;
      devsel_o    <= '0;
    end else begin
      dec_valid_o <= acc_stb_i && legal;
      dec_err_o   <= acc_stb_i && !legal;
      type0_o     <= acc_stb_i && legal;
      devsel_o    <= acc_stb_i ? sel_onehot : '0;
      if (acc_stb_i) begin
        dev_num_o  <= pos;
        func_num_o <= func_c;
        reg_off_o  <= reg_c;
        size_o     <= acc_size_i;
      end
    end
  end
endmodule

// File: rtl/cfg_devsel_decoder_chk.sv
module cfg_devsel_decoder_chk #(
  parameter int NSEL     = 21,
  parameter int DEV_W    = 5,
  parameter int IDSEL_LO = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             acc_stb_i,
  input logic             dec_valid_o,
  input logic             dec_err_o,
  input logic             type0_o,
  input logic [DEV_W-1:0] dev_num_o,
  input logic [NSEL-1:0]  devsel_o
);
  AST_DEVSEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(devsel_o)); // R4
  AST_SEL_MATCHES_DEV: assert property (@(posedge clk) disable iff (rst)
    dec_valid_o |-> devsel_o == (NSEL'(1) << (32'(dev_num_o) - IDSEL_LO))); // R3
  AST_ERR_NO_SELECT: assert property (@(posedge clk) disable iff (rst)
    dec_err_o |-> (devsel_o == '0 && !dec_valid_o)); // R5
  AST_TYPE0_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    type0_o == dec_valid_o); // R8
  AST_NO_STB_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
    !acc_stb_i |=> !(dec_valid_o || dec_err_o)); // R10
  AST_STB_ANSWERED: assert property (@(posedge clk) disable iff (rst)
    acc_stb_i |=> (dec_valid_o != dec_err_o)); // R2
endmodule

bind cfg_devsel_decoder cfg_devsel_decoder_chk #(
  .NSEL(NSEL), .DEV_W(DEV_W), .IDSEL_LO(IDSEL_LO)
) u_chk (
  .clk(clk), .rst(rst), .acc_stb_i(acc_stb_i), .dec_valid_o(dec_valid_o),
  .dec_err_o(dec_err_o), .type0_o(type0_o), .dev_num_o(dev_num_o),
  .devsel_o(devsel_o)
);

// File: tb/cfg_devsel_decoder_bench.sv
module cfg_devsel_decoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stb = 1'b0;
  logic [31:0] addr = '0;
  logic [2:0]  size = '0;
  logic        valid, err, t0;
  logic [7:0]  busn;
  logic [4:0]  devn;
  logic [2:0]  fn;
  logic [7:0]  roff;
  logic [2:0]  szo;
  logic [20:0] dsel;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  cfg_devsel_decoder u_cfg_devsel_decoder (
    .clk(clk), .rst(rst), .acc_stb_i(stb), .cfg_addr_i(addr),
    .acc_size_i(size), .dec_valid_o(valid), .dec_err_o(err), .type0_o(t0),
    .bus_num_o(busn), .dev_num_o(devn), .func_num_o(fn), .reg_off_o(roff),
    .size_o(szo), .devsel_o(dsel)
  );

  localparam int NV = 7;
  localparam logic [31:0] V_ADDR [NV] = '{32'h0000_0800, 32'h8000_0000,
    32'h0001_053F, 32'h0000_07FF, 32'h0000_1800, 32'hFFFF_F800, 32'h0400_0704};
  localparam logic [2:0]  V_SIZE [NV] = '{3'd4, 3'd1, 3'd2, 3'd4, 3'd1, 3'd2, 3'd4};
  localparam logic        V_OK   [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
  localparam logic [4:0]  V_DEV  [NV] = '{5'd11, 5'd31, 5'd16, 5'd0, 5'd0, 5'd0, 5'd26};
  localparam logic [2:0]  V_FN   [NV] = '{3'd0, 3'd0, 3'd5, 3'd7, 3'd0, 3'd0, 3'd7};
  localparam logic [7:0]  V_REG  [NV] = '{8'h00, 8'h00, 8'h3C, 8'hFC, 8'h00, 8'h00, 8'h04};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_result(input string tag, input logic ok, input logic [4:0] dv,
                              input logic [2:0] f, input logic [7:0] r, input logic [2:0] s);
    logic [20:0] exp_sel;
    exp_sel = ok ? (21'd1 << (dv - 5'd11)) : 21'd0;
    check({"R2 valid ", tag}, 32'(valid), 32'(ok));
    check({"R5/R6 err ", tag}, 32'(err), 32'(!ok));
    check({"R3 dev ", tag}, 32'(devn), 32'(ok ? dv : 5'd0));
    check({"R4 devsel ", tag}, 32'(dsel), 32'(exp_sel));
    check({"R7 func ", tag}, 32'(fn), 32'(f));
    check({"R7 reg ", tag}, 32'(roff), 32'(r));
    check({"R9 size ", tag}, 32'(szo), 32'(s));
    check({"R8 type0 ", tag}, 32'(t0), 32'(ok));
    check({"R8 bus ", tag}, 32'(busn), 32'd0);
  endtask

  initial begin
    #(20 * 5000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs zero during reset
    check("R1 valid in reset", 32'(valid), 0);
    check("R1 devsel in reset", 32'(dsel), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 err after reset", 32'(err), 0);
    check("R1 dev after reset", 32'(devn), 0);
    check("R1 size after reset", 32'(szo), 0);

    for (int i = 0; i < NV; i++) begin
      addr = V_ADDR[i]; size = V_SIZE[i]; stb = 1'b1;
      @(negedge clk);
      stb = 1'b0;
      check_result($sformatf("vec%0d", i), V_OK[i], V_DEV[i], V_FN[i], V_REG[i], V_SIZE[i]);
      @(negedge clk);
      check("R2 valid one cycle", 32'(valid), 0);
      check("R4 devsel cleared", 32'(dsel), 0);
      check("R5 err one cycle", 32'(err), 0);
    end

    // R10: address/size changes without strobe are ignored
    addr = 32'h0000_2A14; size = 3'd1;
    @(negedge clk);
    check("R10 no valid", 32'(valid), 0);
    check("R10 no err", 32'(err), 0);
    check("R10 dev held", 32'(devn), 32'd26);
    check("R10 func held", 32'(fn), 32'd7);
    check("R10 reg held", 32'(roff), 32'h04);
    check("R10 size held", 32'(szo), 32'd4);

    // R11: back-to-back strobes
    addr = 32'h0010_0208; size = 3'd2; stb = 1'b1;
    @(negedge clk);
    check_result("R11 first", 1'b1, 5'd20, 3'd2, 8'h08, 3'd2);
    addr = 32'h0000_0000; size = 3'd1;
    @(negedge clk);
    stb = 1'b0;
    check_result("R11 second", 1'b0, 5'd0, 3'd0, 8'h00, 3'd1);
    @(negedge clk);
    check("R11 quiet after", 32'(valid | err), 0);

    // R1: reset mid-run clears held fields
    addr = 32'h0200_0100; size = 3'd4; stb = 1'b1;
    @(negedge clk);
    stb = 1'b0; rst = 1'b1;
    @(negedge clk);
    check("R1 dev cleared by reset", 32'(devn), 0);
    check("R1 func cleared by reset", 32'(fn), 0);
    rst = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule